// File: doc/BRIEF.md
# Indirect Dword Register Window

This block is an eight-byte configuration capability that lets software reach a larger register file through a narrow opening. The opening has two fields. A select byte picks a dword index. A 32-bit data field mirrors the register dword at that index. Software sets the select byte, then reads the data field to fetch a register, or writes the data field to update it.

The register file is outside this block. It is reached over a plain dword port with a combinational read and a write strobe that takes effect at the clock edge. The block works out whether an index falls inside the implemented register range. It returns zero for indices outside that range and never forwards a write to them.

The data field is refreshed from the backing register at the current select after every write that touches the capability. A write that changes only the select byte also causes a refresh. A read on the cycle after such a write returns the fresh value.

Top module: `cdw_window`

## Requirements
- R1: After reset the select byte is 0 and the data field is 0, so both capability dwords read 0x0000_0000.
- R2: The select byte sits in bits 23:16 of capability dword 0 (byte offset 2) and is written when byte enable 2 is set. Bytes 0, 1 and 3 of dword 0 always read zero and ignore writes.
- R3: A write to capability dword 0 never asserts the register-file write strobe.
- R4: A write to capability dword 1 (byte offset 4) with any byte enable set forwards a full dword to the register file at index select. The strobe, address and data are valid in the same cycle as the write.
- R5: In a partial data write, the forwarded dword takes the enabled bytes from the write data and the other bytes from the current data field.
- R6: After any write with at least one byte enable set, on either dword, the data field on the next cycle equals the backing dword at the resulting select.
- R7: When select is at or above REG_DWORDS, no register-file write is issued and the data field reads zero after a refresh.
- R8: A write with no byte enables set changes neither the select byte nor the data field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Capability write strobe |
| cfg_dw | input | 1 | Dword within the capability: 0 holds select, 1 holds data |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rd_dw | input | 1 | Dword selected for cfg_rdata |
| cfg_rdata | output | 32 | Combinational read of the selected capability dword |
| rf_addr | output | 8 | Register-file dword index |
| rf_wr | output | 1 | Register-file write strobe |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data at rf_addr, combinational |

## Verification
The register-file strobe, address and data are combinational. The bench compares them in the same cycle as the capability write, one nanosecond after the falling edge at which the stimulus was applied. Select and data-field updates are registered once, so the capability read that reflects a write is due in the next cycle. The behavioural model commits its own state only after that cycle's comparison, which keeps the expected value aligned with that one-cycle delay. Register-file writes from the block land in the bench's memory at the rising edge. Later refreshes therefore read back what the block wrote.

// File: rtl/cdw_pkg.sv
// Shared constants and types for the indirect dword window.
// Assumes a fixed 32-bit data field and a two-dword capability.
package cdw_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef enum logic {
        CAP_HEAD = 1'b0,  // dword 0: select byte at byte offset 2
        CAP_DATA = 1'b1   // dword 1: data mirror
    } cap_dw_e;

    localparam int SEL_LSB = 16;  // select byte occupies bits 23:16
endpackage

// File: rtl/cdw_select_reg.sv
// Holds the select byte of the window.
// Assumes only byte 2 of dword 0 is writable; other head bytes are constant zero.
module cdw_select_reg
    import cdw_pkg::*;
#(
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_head_sel,
    input  logic [SEL_W-1:0] wr_byte,
    output logic [SEL_W-1:0] sel_q,
    output logic [SEL_W-1:0] sel_next
);
    // Next select: new byte on a select write, else hold.
    always_comb begin
        sel_next = wr_head_sel ? wr_byte : sel_q;
    end

    // Register the select byte with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_next;
    end

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_head_sel |=> sel_q == $past(wr_byte));
    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_head_sel |=> $stable(sel_q));
endmodule

// File: rtl/cdw_range_gate.sv
// Decides whether a dword index falls inside the implemented register file.
// Assumes REG_DWORDS >= 1; when it covers the whole index space every index is valid.
module cdw_range_gate #(
    parameter int SEL_W      = 8,
    parameter int REG_DWORDS = 20
) (
    input  logic [SEL_W-1:0] idx,
    output logic             in_range
);
    localparam int SPACE = 1 << SEL_W;

    generate
        if (REG_DWORDS >= SPACE) begin : g_full
            logic unused_idx;
            // Whole index space is implemented.
            always_comb begin
                unused_idx = ^idx;
                in_range   = 1'b1;
            end
        end else begin : g_part
            localparam logic [SEL_W:0] LIMIT = REG_DWORDS[SEL_W:0];
            // Compare the index against the implemented size.
            always_comb begin
                in_range = ({1'b0, idx} < LIMIT);
            end
        end
    endgenerate
endmodule

// File: rtl/cdw_data_mirror.sv
// Keeps the data field: merges byte-enabled writes and refreshes after any capability write.
// Assumes rf_rdata reflects the index the block presents in the same cycle.
module cdw_data_mirror
    import cdw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch,
    input  logic              data_wr,
    input  logic              in_range,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [DATA_W-1:0] merged,
    output logic [DATA_W-1:0] data_q
);
    logic [DATA_W-1:0] data_next;

    // Byte lane merge of write data over the current field.
    generate
        for (genvar b = 0; b < BE_W; b++) begin : g_lane
            always_comb begin
                merged[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : data_q[b*8 +: 8];
            end
        end
    endgenerate

    // Refresh value: written dword, fetched dword, or zero out of range.
    always_comb begin
        if (!touch)        data_next = data_q;
        else if (!in_range) data_next = '0;
        else if (data_wr)  data_next = merged;
        else               data_next = rf_rdata;
    end

    // Register the mirror with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_next;
    end

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !touch |=> $stable(data_q));
    assert_out_of_range_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (touch && !in_range) |=> data_q == '0);
endmodule

// File: rtl/cdw_window.sv
// Top of the indirect dword window capability.
// Assumes a single write port to the capability and an external register file with
// combinational read and edge-triggered write.
module cdw_window
    import cdw_pkg::*;
#(
    parameter int SEL_W      = 8,
    parameter int REG_DWORDS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_dw,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_rd_dw,
    output logic [31:0]       cfg_rdata,
    output logic [SEL_W-1:0]  rf_addr,
    output logic              rf_wr,
    output logic [31:0]       rf_wdata,
    input  logic [31:0]       rf_rdata
);
    localparam int HEAD_PAD = DATA_W - SEL_LSB - SEL_W;

    logic              touch;
    logic              wr_head_sel;
    logic              data_wr;
    logic              in_range;
    logic [SEL_W-1:0]  sel_q;
    logic [SEL_W-1:0]  sel_next;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] data_q;

    // Decode the write into touch, select load and data write.
    always_comb begin
        touch       = cfg_wr && (cfg_be != '0);
        wr_head_sel = cfg_wr && (cap_dw_e'(cfg_dw) == CAP_HEAD) && cfg_be[SEL_LSB/8];
        data_wr     = touch && (cap_dw_e'(cfg_dw) == CAP_DATA);
    end

    cdw_select_reg #(.SEL_W(SEL_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_head_sel(wr_head_sel),
        .wr_byte    (cfg_wdata[SEL_LSB +: SEL_W]),
        .sel_q      (sel_q),
        .sel_next   (sel_next)
    );

    cdw_range_gate #(.SEL_W(SEL_W), .REG_DWORDS(REG_DWORDS)) u_gate (
        .idx     (sel_next),
        .in_range(in_range)
    );

    cdw_data_mirror u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .touch   (touch),
        .data_wr (data_wr),
        .in_range(in_range),
        .be      (cfg_be),
        .wdata   (cfg_wdata),
        .rf_rdata(rf_rdata),
        .merged  (merged),
        .data_q  (data_q)
    );

    // Register-file port: index follows the resulting select.
    always_comb begin
        rf_addr  = sel_next;
        rf_wr    = data_wr && in_range;
        rf_wdata = merged;
    end

    // Capability read mux; unused head bytes read zero.
    always_comb begin
        if (cap_dw_e'(cfg_rd_dw) == CAP_HEAD)
            cfg_rdata = {{HEAD_PAD{1'b0}}, sel_q, {SEL_LSB{1'b0}}};
        else
            cfg_rdata = data_q;
    end

    assert_no_head_rf_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |-> (cfg_wr && cfg_dw == 1'b1));
    assert_forward_mirrors_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |=> data_q == $past(rf_wdata));
    assert_refresh_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (touch && !data_wr && in_range) |=> data_q == $past(rf_rdata));
endmodule

// File: tb/cdw_window_tb.sv
module cdw_window_tb;
    localparam int REG = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_dw = 1'b0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic        cfg_rd_dw = 1'b0;
    logic [31:0] cfg_rdata;
    logic [7:0]  rf_addr;
    logic        rf_wr;
    logic [31:0] rf_wdata;
    logic [31:0] rf_rdata;

    logic [31:0] mem [256];
    int checks = 0;
    int failures = 0;

    logic [7:0]  m_sel;
    logic [31:0] m_data;

    always #5 clk = ~clk;

    cdw_window #(.SEL_W(8), .REG_DWORDS(REG)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rd_dw(cfg_rd_dw),
        .cfg_rdata(cfg_rdata), .rf_addr(rf_addr), .rf_wr(rf_wr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    assign rf_rdata = mem[rf_addr];

    always @(posedge clk) if (rf_wr) mem[rf_addr] <= rf_wdata;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One cycle: apply inputs, compare with the model, then advance the model.
    task automatic step(input logic wr, input logic dw, input logic [3:0] be,
                        input logic [31:0] wd, input logic rd, input string req);
        logic        touch, nsel_w, inr, ewr;
        logic [7:0]  nsel;
        logic [31:0] mrg, erd;
        @(negedge clk);
        cfg_wr = wr; cfg_dw = dw; cfg_be = be; cfg_wdata = wd; cfg_rd_dw = rd;
        #1;
        touch  = wr && (be != 4'h0);
        nsel_w = wr && !dw && be[2];
        nsel   = nsel_w ? wd[23:16] : m_sel;
        inr    = (nsel < REG);
        for (int b = 0; b < 4; b++) mrg[b*8 +: 8] = be[b] ? wd[b*8 +: 8] : m_data[b*8 +: 8];
        ewr    = touch && dw && inr;
        erd    = rd ? m_data : {8'h00, m_sel, 16'h0000};
        chk(req, "cfg_rdata", cfg_rdata, erd);
        chk(req, "rf_wr", {31'h0, rf_wr}, {31'h0, ewr});
        if (ewr) begin
            chk(req, "rf_addr", {24'h0, rf_addr}, {24'h0, nsel});
            chk(req, "rf_wdata", rf_wdata, mrg);
        end
        if (touch) begin
            if (!inr)    m_data = 32'h0;
            else if (dw) m_data = mrg;
            else         m_data = mem[nsel];
        end
        m_sel = nsel;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0001_0203);
        m_sel = 8'h00; m_data = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset values on both dwords
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b0, "R1");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R1");
        // R2/R6: head write without select byte; pad bytes stay zero, refresh at sel 0
        step(1'b1, 1'b0, 4'b1011, 32'hFFFF_FFFF, 1'b0, "R2");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b0, "R2");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R6");
        // R3/R6: select 5 alone, no rf write, refresh fetches mem[5]
        step(1'b1, 1'b0, 4'b0100, 32'hEE05_EEEE, 1'b1, "R3");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R6");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b0, "R2");
        // R4: full data write
        step(1'b1, 1'b1, 4'hF, 32'h1234_5678, 1'b1, "R4");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R4");
        // R5: partial write merges
        step(1'b1, 1'b1, 4'b0010, 32'h0000_AB00, 1'b1, "R5");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R5");
        step(1'b1, 1'b1, 4'b1001, 32'hC0FF_EE11, 1'b1, "R5");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R5");
        // R8: no byte enables on either dword
        step(1'b1, 1'b1, 4'h0, 32'hDEAD_BEEF, 1'b1, "R8");
        step(1'b1, 1'b0, 4'h0, 32'h00FF_0000, 1'b1, "R8");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b0, "R8");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R8");
        // Boundary: last implemented index 19
        step(1'b1, 1'b0, 4'b0100, 32'h0013_0000, 1'b0, "R6");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R6");
        step(1'b1, 1'b1, 4'hF, 32'h0BAD_F00D, 1'b1, "R4");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R4");
        // R7: first index past the end, then top of the index space
        step(1'b1, 1'b0, 4'b0100, 32'h0014_0000, 1'b1, "R7");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R7");
        step(1'b1, 1'b1, 4'hF, 32'h5555_AAAA, 1'b1, "R7");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R7");
        step(1'b1, 1'b0, 4'b0100, 32'h00FF_0000, 1'b0, "R7");
        step(1'b1, 1'b1, 4'b0001, 32'h0000_0077, 1'b1, "R7");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R7");
        // R6: back to 5 and 19; values written earlier are fetched
        step(1'b1, 1'b0, 4'b0100, 32'h0005_0000, 1'b1, "R6");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R6");
        step(1'b1, 1'b0, 4'b0100, 32'h0013_0000, 1'b1, "R6");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R6");
        // R6: back-to-back data writes then select change
        step(1'b1, 1'b1, 4'b1100, 32'h9876_0000, 1'b1, "R5");
        step(1'b1, 1'b0, 4'b0100, 32'h0000_0000, 1'b1, "R6");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b1, "R6");
        step(1'b0, 1'b0, 4'h0, 32'h0, 1'b0, "R2");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule